// File: doc/BRIEF.md
# Four-Mode 4x4 Integer Block Transform

This core applies one of four separable 4x4 integer transforms to a whole block of sixteen signed coefficients: the video-codec forward core transform, its inverse reconstruction transform, and the forward and inverse Hadamard transforms used on luma DC blocks. The block and a 2-bit mode are presented in parallel with a start strobe. Two clock edges later, the sixteen results appear together with a one-cycle valid strobe.

A single bank of four butterfly processing elements is shared in time. In the first pass, each element transforms one row of the incoming block. The row results go into a feedback register bank. In the second pass, the bank is read out transposed, so each element transforms one column. The transposition and the final reordering are wiring only. The arithmetic uses only adders, subtractors and shifts. The doubled odd taps of the forward transform are one-bit left shifts inside the butterflies. The half-weight taps of the inverse transform are arithmetic right shifts, applied to sign-extended operands. A new block can be accepted every second cycle, which gives a sustained rate of eight coefficients per cycle.

Top module: `xfm4_core`

## Requirements
- R1: With mode 2'b00 the result is Y = C·X·Cᵀ, where C has the rows (1,1,1,1), (2,1,-1,-2), (1,-1,-1,1) and (1,-2,2,-1). Input element (r,c) sits in blkIn bits [(4r+c)·DATA_W +: DATA_W]. Output element (r,c) sits in blkOut bits [(4r+c)·RES_W +: RES_W]. All values are two's complement.
- R2: With mode 2'b01 the 1-D inverse rule is applied first to each row and then to each column. For a vector (a,b,c,d) the rule is: e0=a+c, e1=a-c, e2=(b>>>1)-d, e3=b+(d>>>1). The outputs are (e0+e3, e1+e2, e1-e2, e0-e3), where >>> is an arithmetic shift that rounds toward minus infinity.
- R3: Mode 2'b10 and mode 2'b11 both give Y = H·X·H. H has the rows (1,1,1,1), (1,1,-1,-1), (1,-1,-1,1) and (1,-1,1,-1).
- R4: A start sampled at clock edge k (accepted) raises validOut for exactly the cycle after edge k+1. The result of that block is on blkOut during that cycle.
- R5: A start sampled at the edge that immediately follows an accepted start is ignored. It produces no extra valid pulse and does not change blkOut.
- R6: A start two edges after an accepted start is accepted, so blocks stream at one per two cycles, and each block gets its own correct result.
- R7: Mode and block data are used only at the accepted start edge. Changes on these inputs during the second pass do not alter the result.
- R8: blkOut holds the last result unchanged until the next valid pulse.
- R9: While rstN is low, validOut is 0 and blkOut is all zeros.
- R10: Full-scale inputs (every element -2^(DATA_W-1) or 2^(DATA_W-1)-1, including alternating signs) give exact results without wrap-around. The first-pass values fit in DATA_W+3 bits and the final values fit in RES_W = DATA_W+6 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start strobe; accepted when no block is in its second pass |
| modeIn | input | 2 | 00 forward, 01 inverse, 10 forward Hadamard, 11 inverse Hadamard |
| blkIn | input | 16·DATA_W | Input block, row-major, element (r,c) at index 4r+c |
| validOut | output | 1 | One-cycle strobe marking a fresh result |
| blkOut | output | 16·RES_W | Result block, row-major, element (r,c) at index 4r+c |

## Verification
The embedded properties check the timing contract on every cycle. An accepted start is followed two edges later by exactly one valid pulse. Valid pulses are never adjacent. The output holds steady between pulses. Every first-pass value fits the feedback register width. The arithmetic itself can only be shown by the bench scenarios, which compare each mode against independent matrix and row-column models on random, impulse and full-scale blocks. The same applies to rejecting a start during the second pass, to ignoring late changes of mode and data, and to back-to-back streaming.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

  // growth in bits of one 1-D pass (largest row magnitude sum is 6)
  localparam int PASS_GROW = 3;

  typedef enum logic [1:0] {
    XF_FWD  = 2'b00,
    XF_INV  = 2'b01,
    XF_FHAD = 2'b10,
    XF_IHAD = 2'b11
  } xfm_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // first pass: row results go into feedback bank
    logic phase2;   // PEs read the transposed feedback bank
    logic finish;   // column results go into the output register
  } xfm_ctrl_t;

endpackage

// File: rtl/xfm_pe.sv
module xfm_pe
  import xfm_pkg::*;
#(
  parameter int IN_W  = 19,
  parameter int OUT_W = IN_W + PASS_GROW
) (
  input  xfm_mode_e                mode,
  input  logic [3:0][IN_W-1:0]     vecIn,
  output logic [3:0][OUT_W-1:0]    vecOut
);

  localparam int EXT_W = OUT_W - IN_W;

  logic signed [OUT_W-1:0] opA, opB, opC, opD;
  logic signed [OUT_W-1:0] st0, st1, st2, st3;

  assign opA = {{EXT_W{vecIn[0][IN_W-1]}}, vecIn[0]};
  assign opB = {{EXT_W{vecIn[1][IN_W-1]}}, vecIn[1]};
  assign opC = {{EXT_W{vecIn[2][IN_W-1]}}, vecIn[2]};
  assign opD = {{EXT_W{vecIn[3][IN_W-1]}}, vecIn[3]};

  // first butterfly stage: the inverse pairs differently and uses half taps
  always_comb begin
    if (mode == XF_INV) begin
      st0 = opA + opC;
      st1 = opA - opC;
      st2 = (opB >>> 1) - opD;
      st3 = opB + (opD >>> 1);
    end else begin
      st0 = opA + opD;
      st1 = opA - opD;
      st2 = opB + opC;
      st3 = opB - opC;
    end
  end

  // second butterfly stage
  always_comb begin
    unique case (mode)
      XF_FWD: begin
        vecOut[0] = st0 + st2;
        vecOut[1] = (st1 <<< 1) + st3;
        vecOut[2] = st0 - st2;
        vecOut[3] = st1 - (st3 <<< 1);
      end
      XF_INV: begin
        vecOut[0] = st0 + st3;
        vecOut[1] = st1 + st2;
        vecOut[2] = st1 - st2;
        vecOut[3] = st0 - st3;
      end
      default: begin
        vecOut[0] = st0 + st2;
        vecOut[1] = st1 + st3;
        vecOut[2] = st0 - st2;
        vecOut[3] = st1 - st3;
      end
    endcase
  end

endmodule

// File: rtl/xfm_ctrl.sv
module xfm_ctrl
  import xfm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  xfm_mode_e modeIn,
  output xfm_ctrl_t ctrl,
  output xfm_mode_e peMode
);

  logic      busy;
  xfm_mode_e modeHeld;

  assign ctrl.capture = startIn && !busy;
  assign ctrl.phase2  = busy;
  assign ctrl.finish  = busy;
  assign peMode       = busy ? modeHeld : modeIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      modeHeld <= XF_FWD;
    end else begin
      busy <= ctrl.capture;
      if (ctrl.capture) modeHeld <= modeIn;
    end
  end

  AST_SECOND_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy); // R5

  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (peMode == $past(modeIn))); // R7

endmodule

// File: rtl/xfm_datapath.sv
module xfm_datapath
  import xfm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MID_W  = DATA_W + PASS_GROW,
  parameter int RES_W  = MID_W + PASS_GROW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xfm_ctrl_t             ctrl,
  input  xfm_mode_e             peMode,
  input  logic [16*DATA_W-1:0]  blkIn,
  output logic                  validOut,
  output logic [16*RES_W-1:0]   blkOut
);

  localparam int PAD_W = MID_W - DATA_W;

  logic [3:0][3:0][MID_W-1:0] inRow;   // [row][col], sign-extended input
  logic [3:0][3:0][MID_W-1:0] fbReg;   // [row][col], first-pass results
  logic [3:0][3:0][MID_W-1:0] peIn;    // [pe][elem]
  logic [3:0][3:0][RES_W-1:0] peOut;   // [pe][elem]
  logic [3:0][3:0][RES_W-1:0] resReg;  // [row][col]

  for (genvar r = 0; r < 4; r++) begin : g_row
    for (genvar c = 0; c < 4; c++) begin : g_col
      localparam int IDX = 4 * r + c;
      assign inRow[r][c] = {{PAD_W{blkIn[IDX*DATA_W + DATA_W-1]}},
                            blkIn[IDX*DATA_W +: DATA_W]};
      // PE r takes row r in pass one and column r (transposed bank) in pass two
      assign peIn[r][c] = ctrl.phase2 ? fbReg[c][r] : inRow[r][c];
      assign blkOut[IDX*RES_W +: RES_W] = resReg[r][c];

      AST_PASS1_FIT: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.capture |-> ((peOut[r][c][RES_W-1:MID_W-1] == '0) ||
                          (peOut[r][c][RES_W-1:MID_W-1] == '1))); // R10
    end
  end

  for (genvar p = 0; p < 4; p++) begin : g_pe
    xfm_pe #(
      .IN_W  (MID_W),
      .OUT_W (RES_W)
    ) i_pe (
      .mode   (peMode),
      .vecIn  (peIn[p]),
      .vecOut (peOut[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbReg    <= '0;
      resReg   <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= ctrl.finish;
      for (int p = 0; p < 4; p++) begin
        for (int e = 0; e < 4; e++) begin
          if (ctrl.capture) fbReg[p][e] <= peOut[p][e][MID_W-1:0];
          if (ctrl.finish)  resReg[e][p] <= peOut[p][e];
        end
      end
    end
  end

  AST_HOLD_BETWEEN_PULSES: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> $stable(blkOut)); // R8

endmodule

// File: rtl/xfm4_core.sv
module xfm4_core
  import xfm_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int MID_W = DATA_W + PASS_GROW,
  localparam int RES_W = MID_W + PASS_GROW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [1:0]           modeIn,
  input  logic [16*DATA_W-1:0] blkIn,
  output logic                 validOut,
  output logic [16*RES_W-1:0]  blkOut
);

  xfm_ctrl_t ctrl;
  xfm_mode_e peMode;

  xfm_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .modeIn  (xfm_mode_e'(modeIn)),
    .ctrl    (ctrl),
    .peMode  (peMode)
  );

  xfm_datapath #(
    .DATA_W (DATA_W),
    .MID_W  (MID_W),
    .RES_W  (RES_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .peMode   (peMode),
    .blkIn    (blkIn),
    .validOut (validOut),
    .blkOut   (blkOut)
  );

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> ##1 validOut); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut); // R6

endmodule

// File: tb/test_xfm4_core.sv
module test_xfm4_core;

  localparam int DATA_W = 16;
  localparam int RES_W  = DATA_W + 6;
  localparam int VMAX   = (1 << (DATA_W - 1)) - 1;
  localparam int VMIN   = -(1 << (DATA_W - 1));

  typedef int blk_t[16];

  // kind: 0 random, 1 all max, 2 all min, 3 alternating extremes, 4 impulse
  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  kind;
    logic [31:0] seed;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS[NVEC] = '{
    '{2'b00, 3'd0, 32'd11},
    '{2'b00, 3'd1, 32'd0},
    '{2'b00, 3'd3, 32'd0},
    '{2'b00, 3'd4, 32'd5},
    '{2'b01, 3'd0, 32'd23},
    '{2'b01, 3'd2, 32'd0},
    '{2'b01, 3'd3, 32'd0},
    '{2'b01, 3'd4, 32'd9},
    '{2'b10, 3'd0, 32'd37},
    '{2'b10, 3'd2, 32'd0},
    '{2'b11, 3'd0, 32'd41},
    '{2'b11, 3'd3, 32'd0},
    '{2'b01, 3'd1, 32'd0}
  };

  localparam int CF[16] = '{1, 1, 1, 1,  2, 1, -1, -2,  1, -1, -1, 1,  1, -2, 2, -1};
  localparam int HM[16] = '{1, 1, 1, 1,  1, 1, -1, -1,  1, -1, -1, 1,  1, -1, 1, -1};

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  startIn = 1'b0;
  logic [1:0]            modeIn = 2'b00;
  logic [16*DATA_W-1:0]  blkIn = '0;
  logic                  validOut;
  logic [16*RES_W-1:0]   blkOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  xfm4_core #(.DATA_W(DATA_W)) i_xfm4_core (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .modeIn   (modeIn),
    .blkIn    (blkIn),
    .validOut (validOut),
    .blkOut   (blkOut)
  );

  function automatic blk_t genBlk(input int kind, input int seed);
    blk_t b;
    int s = seed;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] u;
      logic [15:0] h;
      s = s * 1103515245 + 12345;
      u = s;
      h = u[31:16];
      case (kind)
        1: b[k] = VMAX;
        2: b[k] = VMIN;
        3: b[k] = (((k / 4) + (k % 4)) % 2 == 0) ? VMAX : VMIN;
        4: b[k] = (k == (seed % 16)) ? VMIN : 0;
        default: b[k] = int'($signed(h));
      endcase
    end
    return b;
  endfunction

  function automatic void inv1d(input int a, b, c, d, output int y0, y1, y2, y3);
    int e0, e1, e2, e3;
    e0 = a + c;
    e1 = a - c;
    e2 = (b >>> 1) - d;
    e3 = b + (d >>> 1);
    y0 = e0 + e3;
    y1 = e1 + e2;
    y2 = e1 - e2;
    y3 = e0 - e3;
  endfunction

  function automatic blk_t model(input int mode, input blk_t x);
    blk_t y;
    blk_t z;
    if (mode == 1) begin
      for (int r = 0; r < 4; r++)
        inv1d(x[4*r], x[4*r+1], x[4*r+2], x[4*r+3], z[4*r], z[4*r+1], z[4*r+2], z[4*r+3]);
      for (int c = 0; c < 4; c++)
        inv1d(z[c], z[4+c], z[8+c], z[12+c], y[c], y[4+c], y[8+c], y[12+c]);
    end else begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          int acc = 0;
          for (int k = 0; k < 4; k++)
            for (int l = 0; l < 4; l++)
              acc += (mode == 0) ? CF[4*i+k] * x[4*k+l] * CF[4*j+l]
                                 : HM[4*i+k] * x[4*k+l] * HM[4*j+l];
          y[4*i+j] = acc;
        end
    end
    return y;
  endfunction

  function automatic string modeTag(input int mode);
    if (mode == 0) return "R1";
    if (mode == 1) return "R2";
    return "R3";
  endfunction

  task automatic driveBlk(input int mode, input blk_t x);
    modeIn = 2'(mode);
    for (int k = 0; k < 16; k++) blkIn[k*DATA_W +: DATA_W] = x[k][DATA_W-1:0];
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s validOut actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic checkBlk(input string tag, input blk_t exp);
    nChecks++;
    for (int k = 0; k < 16; k++) begin
      logic signed [RES_W-1:0] v;
      v = blkOut[k*RES_W +: RES_W];
      if (int'(v) != exp[k]) begin
        nFails++;
        $display("FAIL %s element %0d actual=%0d expected=%0d", tag, k, int'(v), exp[k]);
        break;
      end
    end
  endtask

  // one isolated block: start sampled at edge k, result after edge k+1
  task automatic runOne(input int mode, input blk_t x, input string tag);
    blk_t e = model(mode, x);
    @(negedge clk);
    startIn = 1'b1;
    driveBlk(mode, x);
    @(negedge clk);
    startIn = 1'b0;
    checkBit("R4 no early valid", validOut, 1'b0);
    @(negedge clk);
    checkBit("R4 valid", validOut, 1'b1);
    checkBlk(tag, e);
    @(negedge clk);
    checkBit("R4 single pulse", validOut, 1'b0);
    checkBlk("R8 hold", e);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    blk_t zero;
    blk_t a, b, ea, eb;
    for (int k = 0; k < 16; k++) zero[k] = 0;

    // R9 reset state
    repeat (3) @(negedge clk);
    checkBit("R9 reset", validOut, 1'b0);
    checkBlk("R9 reset", zero);
    rstN = 1'b1;

    // table walk: R1, R2, R3 per mode; extreme kinds also cover R10
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = modeTag(int'(VECS[v].mode));
      if (VECS[v].kind inside {3'd1, 3'd2, 3'd3}) tag = {tag, " R10"};
      runOne(int'(VECS[v].mode), genBlk(int'(VECS[v].kind), int'(VECS[v].seed)), tag);
    end

    // R5 and R7: start held high into the second pass with new mode and data
    a  = genBlk(0, 77);
    b  = genBlk(0, 99);
    ea = model(0, a);
    @(negedge clk);
    startIn = 1'b1;
    driveBlk(0, a);
    @(negedge clk);
    driveBlk(1, b);
    @(negedge clk);
    startIn = 1'b0;
    checkBit("R7 valid", validOut, 1'b1);
    checkBlk("R7 late change ignored", ea);
    @(negedge clk);
    checkBit("R5 in-flight start ignored", validOut, 1'b0);
    checkBlk("R5 output unchanged", ea);

    // R6 back-to-back streaming, one block every two cycles
    a  = genBlk(0, 1234);
    b  = genBlk(4, 3);
    ea = model(2, a);
    eb = model(1, b);
    @(negedge clk);
    startIn = 1'b1;
    driveBlk(2, a);
    @(negedge clk);
    startIn = 1'b0;
    @(negedge clk);
    checkBit("R6 first valid", validOut, 1'b1);
    checkBlk("R6 first block", ea);
    startIn = 1'b1;
    driveBlk(1, b);
    @(negedge clk);
    startIn = 1'b0;
    checkBit("R6 gap", validOut, 1'b0);
    @(negedge clk);
    checkBit("R6 second valid", validOut, 1'b1);
    checkBlk("R6 second block", eb);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule